// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This block lets processors on one chip pass short messages to each other. It has a number of independent channels. A sender claims a channel by writing a one-hot owner bit, loads eight data words and triggers a send. The send drives the interrupt lines that the channel's destination mask selects. The receiver clears its destination bits. The channel then reports an acknowledge and raises the owner's interrupt line. The owner clears that acknowledge, and the channel is ready to send again.

Software reaches all of this through a simple register bus with address, write data, write enable, read enable and registered read data. The interrupt outputs form one vector, with one bit for each processor interrupt line. A global write lock keeps all channel registers closed until a fixed key is written to the lock register.

Each channel uses a 0x40-byte window at channel × 0x40. The word offsets inside the window are: owner 0x00, destination mask 0x04, destination clear 0x08, pending destinations 0x0C, mode/status 0x10, interrupt mask 0x14, acknowledge clear 0x18, send 0x1C, and data 0x20–0x3C. The lock register is at 0xA00.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every channel reads mode 0x10 (idle), the lock register reads 1, `irq_o` is all zero and `rdata` is zero.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, and reading 0xA00 then returns 0. Writing any other value to 0xA00 relocks it, and reading returns 1.
- R3: While the block is locked, writes to channel registers leave channel state unchanged, and no new interrupt line rises.
- R4: Channel n decodes addresses n×0x40 to n×0x40+0x3F. A write in one channel's window is not visible in another channel.
- R5: While a channel is idle, a one-hot write to its owner register (0x00) claims it. The owner then reads back that bit and mode reads 0x20 (bit 5, ready). A write that is not one-hot leaves the channel idle with owner 0.
- R6: While a channel is owned, a nonzero write to the owner register is ignored. A zero write from the ready state releases the channel to idle (mode 0x10, owner 0).
- R7: The eight data words at offsets 0x20–0x3C store and read back independently.
- R8: In the ready state, writing a value that contains the owner bit to send (0x1C) copies the destination mask into pending destinations (0x0C). It also sets mode bit 6 (busy), and the unmasked destination lines are high right after that write edge. A send value without the owner bit is ignored.
- R9: A 1 in interrupt mask bit k (0x14) holds `irq_o[k]` low. Clearing the mask bit releases the line while its source is still pending.
- R10: Writing 1s to destination clear (0x08) clears those pending bits. In automatic mode (mode bit 0 = 1), a clear that hits the destination mask while busy moves the channel to acknowledge (mode bit 7) and raises the owner's line right after that edge.
- R11: In manual mode (mode bit 0 = 0), a destination clear leaves the channel busy. A mode write with bit 7 set while busy then enters acknowledge.
- R12: In acknowledge, writing a value that contains the owner bit to 0x18 returns the channel to ready (mode bit 5) and drops the owner's line.
- R13: `rdata` takes the addressed register's value at the clock edge that samples `rd_en`, and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | IRQ_W | Interrupt lines, OR of all channels |

## Verification
Every register write takes effect at the clock edge that samples `wr_en`. The interrupt vector comes from channel state through logic only, so a send, a clear or a mask change shows on `irq_o` in the same cycle that follows that edge. The bench drives each strobe for one cycle from a falling edge and checks `irq_o` at the next falling edge, with no added wait. Reads add one register stage, and the bench samples `rdata` at the falling edge after the edge that captured `rd_en`.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
    localparam int MSG_WORDS = 8;

    localparam logic [3:0] OFS_OWNER = 4'd0;
    localparam logic [3:0] OFS_DST   = 4'd1;
    localparam logic [3:0] OFS_DCLR  = 4'd2;
    localparam logic [3:0] OFS_PEND  = 4'd3;
    localparam logic [3:0] OFS_MODE  = 4'd4;
    localparam logic [3:0] OFS_MASK  = 4'd5;
    localparam logic [3:0] OFS_ACLR  = 4'd6;
    localparam logic [3:0] OFS_SEND  = 4'd7;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
    localparam int          LOCK_ADDR  = 'hA00;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_READY = 2'd1,
        CH_BUSY  = 2'd2,
        CH_ACK   = 2'd3
    } chan_state_e;
endpackage

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
    import ipc_mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [IRQ_W-1:0]  irq
);
    typedef struct packed {
        logic [IRQ_W-1:0]                  owner;
        logic [IRQ_W-1:0]                  dst;
        logic [IRQ_W-1:0]                  pend;
        logic [IRQ_W-1:0]                  mask;
        logic                              auto_ack;
        chan_state_e                       st;
        logic [MSG_WORDS-1:0][DATA_W-1:0]  msg;
    } chan_t;

    chan_t d, q;
    logic [IRQ_W-1:0] wbits;
    logic             owner_hit;

    always_comb begin
        d         = q;
        wbits     = wdata[IRQ_W-1:0];
        owner_hit = |(wbits & q.owner);
        if (wr_en) begin
            if (word[3]) begin
                d.msg[word[2:0]] = wdata;
            end else begin
                case (word)
                    OFS_OWNER: begin
                        if (q.st == CH_IDLE && $onehot(wbits)) begin
                            d.owner = wbits;
                            d.st    = CH_READY;
                        end else if (q.st == CH_READY && wbits == '0) begin
                            d.owner = '0;
                            d.st    = CH_IDLE;
                        end
                    end
                    OFS_DST:  d.dst  = wbits;
                    OFS_MASK: d.mask = wbits;
                    OFS_DCLR: begin
                        d.pend = q.pend & ~wbits;
                        if (q.st == CH_BUSY && q.auto_ack && |(wbits & q.dst))
                            d.st = CH_ACK;
                    end
                    OFS_MODE: begin
                        d.auto_ack = wdata[0];
                        if (q.st == CH_BUSY && wdata[7])
                            d.st = CH_ACK;
                    end
                    OFS_ACLR: begin
                        if (q.st == CH_ACK && owner_hit)
                            d.st = CH_READY;
                    end
                    OFS_SEND: begin
                        if (q.st == CH_READY && owner_hit) begin
                            d.pend = q.dst;
                            d.st   = CH_BUSY;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (word[3]) begin
            rd_word = q.msg[word[2:0]];
        end else begin
            case (word)
                OFS_OWNER: rd_word = DATA_W'(q.owner);
                OFS_DST:   rd_word = DATA_W'(q.dst);
                OFS_PEND:  rd_word = DATA_W'(q.pend);
                OFS_MASK:  rd_word = DATA_W'(q.mask);
                OFS_MODE:  rd_word = DATA_W'({q.st == CH_ACK, q.st == CH_BUSY,
                                              q.st == CH_READY, q.st == CH_IDLE,
                                              3'b000, q.auto_ack});
                default:   rd_word = '0;
            endcase
        end
    end

    assign irq = (q.pend | ((q.st == CH_ACK) ? q.owner : '0)) & ~q.mask;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic [IRQ_W-1:0]  irq_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic              lock;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t d, q;

    logic [CH_W-1:0]   sel;
    logic              ch_hit;
    logic              lock_hit;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] chan_rd  [NUM_CH];
    logic [IRQ_W-1:0]  chan_irq [NUM_CH];
    logic              unused_lsb;

    assign unused_lsb = ^addr[1:0];
    assign sel        = addr[6 +: CH_W];
    assign ch_hit     = (int'(addr >> 6) < NUM_CH);
    assign lock_hit   = (int'(addr) == LOCK_ADDR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ipc_mbox_chan #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && !q.lock && ch_hit && (sel == CH_W'(i))),
            .word    (addr[5:2]),
            .wdata   (wdata),
            .rd_word (chan_rd[i]),
            .irq     (chan_irq[i])
        );
    end

    always_comb begin
        irq_o = '0;
        for (int i = 0; i < NUM_CH; i++) irq_o = irq_o | chan_irq[i];
    end

    always_comb begin
        if (lock_hit)    rd_mux = DATA_W'(q.lock);
        else if (ch_hit) rd_mux = chan_rd[sel];
        else             rd_mux = '0;
    end

    always_comb begin
        d = q;
        if (wr_en && lock_hit) d.lock = (wdata != DATA_W'(UNLOCK_KEY));
        if (rd_en)             d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lock  <= 1'b1;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [IRQ_W-1:0]  irq_o,
    input logic              lock_st
);
    logic lock_wr;
    assign lock_wr = wr_en && (int'(addr) == LOCK_ADDR);

    a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata == DATA_W'(UNLOCK_KEY)) |=> !lock_st);

    a_r2_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata != DATA_W'(UNLOCK_KEY)) |=> lock_st);

    a_r2_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) == LOCK_ADDR) |=> (rdata == DATA_W'($past(lock_st))));

    a_r3_locked_no_new_irq: assert property (@(posedge clk) disable iff (!rst_n)
        lock_st |=> ((irq_o & ~$past(irq_o)) == '0));

    a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq_o(irq_o), .lock_st(q.lock)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IRQ_W  = 32;
    localparam logic [11:0] LOCK = 12'hA00;
    localparam logic [11:0] CH3  = 12'h0C0;
    localparam logic [11:0] CH30 = 12'h780;
    localparam logic [11:0] CH31 = 12'h7C0;
    localparam logic [31:0] KEY  = 32'h1ACC_E551;
    localparam logic [31:0] OWN  = 32'h0000_0004;
    localparam logic [31:0] DST  = 32'h0000_0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic [IRQ_W-1:0]  irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ipc_mailbox #(.NUM_CH(32), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", irq_o, 32'h0);
        rd_check("R1 lock", LOCK, 32'h1);
        rd_check("R1 mode ch3", CH3 + 12'h10, 32'h10);
        rd_check("R1 mode ch31", CH31 + 12'h10, 32'h10);
    endtask

    task automatic t_locked();
        wr(CH3, OWN);
        rd_check("R3 owner", CH3, 32'h0);
        rd_check("R3 mode", CH3 + 12'h10, 32'h10);
        check("R3 irq", irq_o, 32'h0);
    endtask

    task automatic t_lock();
        wr(LOCK, KEY);
        rd_check("R2 unlocked", LOCK, 32'h0);
        wr(LOCK, 32'h1234_5678);
        rd_check("R2 relocked", LOCK, 32'h1);
        wr(LOCK, KEY);
        rd_check("R2 unlocked again", LOCK, 32'h0);
    endtask

    task automatic t_rdata();
        logic [31:0] v;
        rd(LOCK, v);
        wr(CH3 + 12'h14, 32'h0);
        repeat (3) @(negedge clk);
        check("R13 hold", rdata, v);
    endtask

    task automatic t_claim();
        wr(CH3, 32'h6);
        rd_check("R5 non-onehot", CH3, 32'h0);
        rd_check("R5 still idle", CH3 + 12'h10, 32'h10);
        wr(CH3, OWN);
        rd_check("R5 owner", CH3, OWN);
        rd_check("R5 ready", CH3 + 12'h10, 32'h20);
        wr(CH3, 32'h8);
        rd_check("R6 second claim", CH3, OWN);
    endtask

    task automatic t_data();
        for (int i = 0; i < 8; i++) wr(CH3 + 12'h20 + 12'(4 * i), 32'hA000_0000 + 32'(i) * 32'h1111);
        for (int i = 0; i < 8; i++) rd_check("R7 data", CH3 + 12'h20 + 12'(4 * i), 32'hA000_0000 + 32'(i) * 32'h1111);
        wr(CH31 + 12'h3C, 32'hDEAD_BEEF);
        rd_check("R4 ch31 word7", CH31 + 12'h3C, 32'hDEAD_BEEF);
        rd_check("R4 ch30 word7", CH30 + 12'h3C, 32'h0);
    endtask

    task automatic t_send_auto();
        wr(CH3 + 12'h04, DST);
        wr(CH3 + 12'h10, 32'h1);
        rd_check("R10 auto mode", CH3 + 12'h10, 32'h21);
        wr(CH3 + 12'h1C, 32'h8);
        check("R8 wrong bit irq", irq_o, 32'h0);
        rd_check("R8 wrong bit mode", CH3 + 12'h10, 32'h21);
        wr(CH3 + 12'h1C, OWN);
        check("R8 irq", irq_o, DST);
        rd_check("R8 pending", CH3 + 12'h0C, DST);
        rd_check("R8 busy", CH3 + 12'h10, 32'h41);
        wr(CH3 + 12'h08, DST);
        check("R10 ack irq", irq_o, OWN);
        rd_check("R10 ack mode", CH3 + 12'h10, 32'h81);
        rd_check("R10 pending cleared", CH3 + 12'h0C, 32'h0);
        wr(CH3 + 12'h18, OWN);
        check("R12 irq dropped", irq_o, 32'h0);
        rd_check("R12 ready", CH3 + 12'h10, 32'h21);
    endtask

    task automatic t_mask();
        wr(CH3 + 12'h14, DST);
        wr(CH3 + 12'h1C, OWN);
        check("R9 masked", irq_o, 32'h0);
        rd_check("R9 pending", CH3 + 12'h0C, DST);
        wr(CH3 + 12'h14, 32'h0);
        check("R9 unmasked", irq_o, DST);
        wr(CH3 + 12'h08, DST);
        wr(CH3 + 12'h18, OWN);
        check("R9 done", irq_o, 32'h0);
    endtask

    task automatic t_manual();
        wr(CH3 + 12'h10, 32'h0);
        rd_check("R11 manual", CH3 + 12'h10, 32'h20);
        wr(CH3 + 12'h1C, OWN);
        wr(CH3 + 12'h08, DST);
        check("R11 no ack irq", irq_o, 32'h0);
        rd_check("R11 still busy", CH3 + 12'h10, 32'h40);
        wr(CH3 + 12'h10, 32'h80);
        check("R11 ack irq", irq_o, OWN);
        rd_check("R11 ack", CH3 + 12'h10, 32'h80);
        wr(CH3 + 12'h18, OWN);
        rd_check("R12 ready manual", CH3 + 12'h10, 32'h20);
    endtask

    task automatic t_release();
        wr(CH3, 32'h0);
        rd_check("R6 released", CH3 + 12'h10, 32'h10);
        rd_check("R6 owner zero", CH3, 32'h0);
        wr(LOCK, 32'h0);
        wr(CH3, OWN);
        rd_check("R3 relocked claim", CH3, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_lock();
        t_rdata();
        t_claim();
        t_data();
        t_send_auto();
        t_mask();
        t_manual();
        t_release();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule